// File: doc/BRIEF.md
# Flash Fast-Mode Program Sequencer

This block watches the write cycles of a flash bus and decodes the command sequences that start a program operation. It has two modes. In standard mode a program takes four writes. The first two are fixed unlock writes. The third is the program setup. The fourth carries the target address and data. A fast-mode entry command, reached through the same two unlock writes, switches the block into a shortened mode. In that mode a program takes only two writes: the setup byte, then the address and data.

On the final write of either sequence, the block issues a one-cycle program request. The request carries the captured address and data. Fast mode stays active until a two-write exit sequence is written, and the first write of that exit must address the bank in which fast mode was entered. An erase setup byte written in fast mode is prohibited. The block flags it with a one-cycle error pulse and drops it. The block drives no array, erase logic or read path. It only produces the request for a program engine downstream.

Command matching uses the low byte of each write and, for the keyed writes, the low 11 address bits. The bank is the top `BANK_W` address bits.

Top module: `fast_prog_seq`

## Requirements
- R1: While reset is held and right after it, `fast_mode`, `prog_req` and `erase_err` are all 0.
- R2: In standard mode, four writes of 555h/AAh, 2AAh/55h, 555h/A0h and then PA/PD raise `prog_req` for one cycle. It is visible after the clock edge that takes the fourth write, with `prog_addr`=PA and `prog_data`=PD.
- R3: In standard mode, any write in the first three slots that does not match the expected address/data pair returns the sequencer to idle, and the write that follows is not programmed.
- R4: In standard mode, the writes 555h/AAh, 2AAh/55h and 555h/20h set `fast_mode` after the third write. The bank bits of that third write are recorded as the fast-mode bank.
- R5: In fast mode, a write with data A0h (any address) followed by a PA/PD write raises `prog_req` with PA and PD, with the same timing as R2.
- R6: In fast mode, writes whose data is not A0h, 80h or 90h (including the unlock pairs) are ignored, and the write after them is not programmed.
- R7: In fast mode, a write of 90h to an address in the recorded bank followed by a write of 00h clears `fast_mode` after the second write. A two-write program is then no longer accepted, and only the four-write form of R2 programs.
- R8: In fast mode, 90h written to a different bank is ignored, and 90h followed by anything other than 00h leaves fast mode active.
- R9: In fast mode, a write of 80h raises `erase_err` for exactly one cycle after that write, leaves `fast_mode` set, and the following write is not programmed.
- R10: In standard mode, 80h in the third slot after the unlocks gives no `erase_err` and no program.
- R11: Cycles with `wr_en` low between the writes of a sequence do not disturb it.
- R12: `prog_req` never stays high for two consecutive cycles.
- R13: The PA/PD write is taken as data whatever its value, including a command byte such as A0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write is presented this cycle |
| wr_addr | input | ADDR_W | Write address; top BANK_W bits select the bank |
| wr_data | input | DATA_W | Write data; low byte holds command codes |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address captured from the final write |
| prog_data | output | DATA_W | Program data captured from the final write |
| fast_mode | output | 1 | Fast mode is active |
| erase_err | output | 1 | One-cycle pulse: erase setup attempted in fast mode |

## Verification
A wrong sequencer state shows up at the ports on the first write that depends on it. A stale unlock state produces a `prog_req` from a two-write sequence in standard mode, or no request at all after a correct four-write sequence. Either one appears one edge after the final write. A wrong recorded bank or a broken exit path leaves `fast_mode` at the wrong level right after the exit's second write, and the very next two-write attempt then confirms the error. A setup byte taken in the wrong state corrupts `prog_addr`/`prog_data`, and the scoreboard compares these on the same request.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_UNLK1    = 3'd1,
        ST_UNLK2    = 3'd2,
        ST_STD_PA   = 3'd3,
        ST_FST_IDLE = 3'd4,
        ST_FST_PA   = 3'd5,
        ST_FST_EXIT = 3'd6
    } seq_st_e;

    localparam int CMD_W  = 8;
    localparam int KEY_AW = 11;

    localparam logic [CMD_W-1:0] CMD_KEY_A    = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_KEY_B    = 8'h55;
    localparam logic [CMD_W-1:0] CMD_PGM      = 8'hA0;
    localparam logic [CMD_W-1:0] CMD_FAST_ON  = 8'h20;
    localparam logic [CMD_W-1:0] CMD_ERASE    = 8'h80;
    localparam logic [CMD_W-1:0] CMD_FAST_X1  = 8'h90;
    localparam logic [CMD_W-1:0] CMD_FAST_X2  = 8'h00;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 11'h2AA;

    typedef struct packed {
        logic key1;
        logic key2;
        logic pgm_std;
        logic fast_on;
        logic pgm_any;
        logic erase;
        logic exit1;
        logic exit2;
    } cmd_hit_t;

endpackage

// File: rtl/fps_cmd_decode.sv
module fps_cmd_decode
    import fps_pkg::*;
(
    input  logic [KEY_AW-1:0] key_addr,
    input  logic [CMD_W-1:0]  cmd,
    output cmd_hit_t          hit
);

    logic at_a;
    logic at_b;

    always_comb begin
        at_a        = (key_addr == KEY_ADDR_A);
        at_b        = (key_addr == KEY_ADDR_B);
        hit         = '0;
        hit.key1    = at_a && (cmd == CMD_KEY_A);
        hit.key2    = at_b && (cmd == CMD_KEY_B);
        hit.pgm_std = at_a && (cmd == CMD_PGM);
        hit.fast_on = at_a && (cmd == CMD_FAST_ON);
        hit.pgm_any = (cmd == CMD_PGM);
        hit.erase   = (cmd == CMD_ERASE);
        hit.exit1   = (cmd == CMD_FAST_X1);
        hit.exit2   = (cmd == CMD_FAST_X2);
    end

endmodule

// File: rtl/fps_seq_fsm.sv
module fps_seq_fsm
    import fps_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cmd_hit_t          hit,
    input  logic [BANK_W-1:0] wr_bank,
    output logic              prog_fire,
    output logic              fast_mode,
    output logic              erase_err
);

    typedef struct packed {
        seq_st_e           st;
        logic [BANK_W-1:0] bank;
        logic              err;
    } fsm_t;

    fsm_t fsm_d;
    fsm_t fsm_q;
    logic bank_hit;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.err = 1'b0;
        bank_hit  = (wr_bank == fsm_q.bank);
        prog_fire = wr_en && ((fsm_q.st == ST_STD_PA) || (fsm_q.st == ST_FST_PA));
        if (wr_en) begin
            case (fsm_q.st)
                ST_IDLE: begin
                    if (hit.key1) fsm_d.st = ST_UNLK1;
                end
                ST_UNLK1: begin
                    fsm_d.st = hit.key2 ? ST_UNLK2 : ST_IDLE;
                end
                ST_UNLK2: begin
                    if (hit.pgm_std) begin
                        fsm_d.st = ST_STD_PA;
                    end else if (hit.fast_on) begin
                        fsm_d.st   = ST_FST_IDLE;
                        fsm_d.bank = wr_bank;
                    end else begin
                        fsm_d.st = ST_IDLE;
                    end
                end
                ST_STD_PA: begin
                    fsm_d.st = ST_IDLE;
                end
                ST_FST_IDLE: begin
                    if (hit.pgm_any) begin
                        fsm_d.st = ST_FST_PA;
                    end else if (hit.erase) begin
                        fsm_d.err = 1'b1;
                    end else if (hit.exit1 && bank_hit) begin
                        fsm_d.st = ST_FST_EXIT;
                    end
                end
                ST_FST_PA: begin
                    fsm_d.st = ST_FST_IDLE;
                end
                ST_FST_EXIT: begin
                    fsm_d.st = hit.exit2 ? ST_IDLE : ST_FST_IDLE;
                end
                default: begin
                    fsm_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, bank: '0, err: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign fast_mode = (fsm_q.st == ST_FST_IDLE) || (fsm_q.st == ST_FST_PA) ||
                       (fsm_q.st == ST_FST_EXIT);
    assign erase_err = fsm_q.err;

endmodule

// File: rtl/fps_prog_capture.sv
module fps_prog_capture #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = fire;
        if (fire) begin
            cap_d.a = addr;
            cap_d.d = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign req      = cap_q.vld;
    assign req_addr = cap_q.a;
    assign req_data = cap_q.d;

endmodule

// File: rtl/fast_prog_seq.sv
module fast_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              fast_mode,
    output logic              erase_err
);

    localparam int BANK_LSB = ADDR_W - BANK_W;

    cmd_hit_t          hit;
    logic              fire;
    logic [BANK_W-1:0] bank;

    assign bank = wr_addr[ADDR_W-1:BANK_LSB];

    fps_cmd_decode u_dec (
        .key_addr (wr_addr[KEY_AW-1:0]),
        .cmd      (wr_data[CMD_W-1:0]),
        .hit      (hit)
    );

    fps_seq_fsm #(.BANK_W(BANK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit       (hit),
        .wr_bank   (bank),
        .prog_fire (fire),
        .fast_mode (fast_mode),
        .erase_err (erase_err)
    );

    fps_prog_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .addr     (wr_addr),
        .data     (wr_data),
        .req      (prog_req),
        .req_addr (prog_addr),
        .req_data (prog_data)
    );

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [DATA_W-1:0] prog_data,
    input logic              fast_mode,
    input logic              erase_err
);

    p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    p_req_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_en));

    p_req_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_err |-> (fast_mode && $past(wr_en) && $past(wr_data[7:0]) == 8'h80));

    p_err_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_err |-> !prog_req);

    p_fast_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_mode) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h20));

    p_fast_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_mode) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h00));

    p_std_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_mode && !$past(fast_mode)) |-> !erase_err);

endmodule

bind fast_prog_seq fps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .fast_mode (fast_mode),
    .erase_err (erase_err)
);

// File: tb/fast_prog_seq_tb_top.sv
module fast_prog_seq_tb_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 8;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              prog_req;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic              fast_mode;
    logic              erase_err;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic [ADDR_W+DATA_W-1:0] exp_q[$];
    string tag_q[$];
    logic prev_req = 1'b0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fast_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .fast_mode(fast_mode), .erase_err(erase_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // monitor: scoreboard pops one expected item per request
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            if (prog_req && prev_req) check("R12", "prog_req held two cycles", 1, 0);
            if (prog_req) begin
                if (exp_q.size() == 0) begin
                    check(cur_req, "unexpected prog_req", 1, 0);
                end else begin
                    logic [ADDR_W+DATA_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, "prog_addr", int'(prog_addr), int'(e[ADDR_W+DATA_W-1:DATA_W]));
                    check(t, "prog_data", int'(prog_data), int'(e[DATA_W-1:0]));
                end
            end
            prev_req = prog_req;
        end
    end

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int gap = 0);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #(CLK_P/4);
        wr_en = 1'b0;
    endtask

    task automatic push_exp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string t);
        exp_q.push_back({a, d});
        tag_q.push_back(t);
    endtask

    task automatic std_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input string t, input int gap = 0);
        bus_wr(22'h555, 8'hAA, gap);
        bus_wr(22'h2AA, 8'h55, gap);
        bus_wr(22'h555, 8'hA0, gap);
        push_exp(a, d, t);
        bus_wr(a, d, gap);
    endtask

    task automatic fast_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string t);
        bus_wr(22'h3F_0123, 8'hA0);
        push_exp(a, d, t);
        bus_wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("WDOG", "watchdog expired", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1", "fast_mode in reset", int'(fast_mode), 0);
        check("R1", "prog_req in reset", int'(prog_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_P/4);
        check("R1", "erase_err after reset", int'(erase_err), 0);
        check("R1", "fast_mode after reset", int'(fast_mode), 0);

        // R2: standard four-write program
        cur_req = "R2";
        std_prog(22'h12345, 8'h5A, "R2");
        check("R2", "fast_mode stays clear", int'(fast_mode), 0);
        std_prog(22'h3FFFFF, 8'hC3, "R2");

        // R11: idle cycles between writes
        cur_req = "R11";
        std_prog(22'h0ABCD, 8'h81, "R11", 3);

        // R13: data equal to a command code is programmed
        cur_req = "R13";
        std_prog(22'h00555, 8'hA0, "R13");

        // R3: mismatches return to idle
        cur_req = "R3";
        bus_wr(22'h555, 8'hAA); bus_wr(22'h2AA, 8'h56); bus_wr(22'h555, 8'hA0); bus_wr(22'h100, 8'h11);
        bus_wr(22'h554, 8'hAA); bus_wr(22'h2AA, 8'h55); bus_wr(22'h555, 8'hA0); bus_wr(22'h101, 8'h12);
        bus_wr(22'h555, 8'hAA); bus_wr(22'h2AA, 8'h55); bus_wr(22'h556, 8'hA0); bus_wr(22'h102, 8'h13);
        check("R3", "queue drained", exp_q.size(), 0);
        std_prog(22'h00777, 8'h3C, "R3");

        // R10: erase setup in standard mode
        cur_req = "R10";
        bus_wr(22'h555, 8'hAA); bus_wr(22'h2AA, 8'h55); bus_wr(22'h555, 8'h80);
        check("R10", "erase_err in standard mode", int'(erase_err), 0);
        bus_wr(22'h200, 8'h33);
        check("R10", "fast_mode", int'(fast_mode), 0);

        // R4: enter fast mode in bank 2
        cur_req = "R4";
        bus_wr(22'h555, 8'hAA); bus_wr(22'h2AA, 8'h55);
        bus_wr({2'b10, 20'h00555}, 8'h20);
        check("R4", "fast_mode after entry", int'(fast_mode), 1);

        // R5: two-write program
        cur_req = "R5";
        fast_prog(22'h04444, 8'h44, "R5");
        fast_prog(22'h2A5A5, 8'hFF, "R5");
        fast_prog(22'h00001, 8'h00, "R5");
        check("R5", "fast_mode kept", int'(fast_mode), 1);

        // R6: unlock pairs ignored in fast mode
        cur_req = "R6";
        bus_wr(22'h555, 8'hAA); bus_wr(22'h2AA, 8'h55); bus_wr(22'h300, 8'h44);
        check("R6", "fast_mode kept", int'(fast_mode), 1);

        // R9: erase setup in fast mode
        cur_req = "R9";
        bus_wr(22'h555, 8'h80);
        check("R9", "erase_err pulse", int'(erase_err), 1);
        @(posedge clk);
        #(CLK_P/4);
        check("R9", "erase_err one cycle", int'(erase_err), 0);
        bus_wr(22'h400, 8'h66);
        check("R9", "fast_mode kept", int'(fast_mode), 1);

        // R8: wrong bank, wrong second byte
        cur_req = "R8";
        bus_wr({2'b01, 20'h00000}, 8'h90); bus_wr(22'h0, 8'h00);
        check("R8", "wrong bank keeps fast", int'(fast_mode), 1);
        bus_wr({2'b10, 20'h00000}, 8'h90); bus_wr(22'h0, 8'h77);
        check("R8", "bad second byte keeps fast", int'(fast_mode), 1);
        fast_prog(22'h05555, 8'h21, "R8");

        // R7: proper exit
        cur_req = "R7";
        bus_wr({2'b10, 20'h12345}, 8'h90); bus_wr(22'h0, 8'h00);
        check("R7", "fast_mode after exit", int'(fast_mode), 0);
        bus_wr(22'h3F_0123, 8'hA0); bus_wr(22'h500, 8'h99);
        std_prog(22'h06006, 8'h5E, "R7");

        repeat (3) @(posedge clk);
        #(CLK_P/2);
        check("R2", "all expected requests seen", exp_q.size(), 0);
        done = 1'b1;
        report();
    end

endmodule